// File: doc/BRIEF.md
# Instruction Stream Boundary Decoder

The block takes a stream of machine-code bytes, one byte per transfer, and cuts it into whole instructions. Each instruction begins with one opcode byte. The prefix byte 0x18 is the exception: it selects a second opcode page, and the byte after it completes a two-byte opcode. The block looks up the opcode in a built-in format table. The table gives the addressing mode and the number of operand bytes, from zero to three. The block then gathers that many further bytes and presents one instruction record. The record holds the opcode, the mode code, the operand bytes and the total length in bytes.

Both the byte input and the record output are valid/ready streams. A byte is taken on a rising clock edge when `in_valid` and `in_ready` are both high. A record is handed over when `out_valid` and `out_ready` are both high. `in_ready` is low only while a finished record is waiting and `out_ready` is low. In that case the record stays unchanged and no byte is taken. When the output is free the block takes one byte per cycle. The record for an instruction appears on the cycle after its final byte is taken. If the previous record is handed over on the same edge, the next record can follow with no gap.

Top module: `instr_split`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Byte 0x01 gives a record with opcode 0x0001, mode 0 (inherent), operand 0 and length 1.
- R3: The 8-bit immediate opcodes 0x86, 0xC6, 0x8B and 0xCB give mode 1 and take one operand byte. The operand field holds that byte and the length is 2.
- R4: The direct opcodes 0x96, 0xD6, 0xDC, 0x9B, 0xDB, 0xD3, 0x97, 0xD7 and 0xDD give mode 2 and take one operand byte. The length is 2.
- R5: The 16-bit immediate opcodes 0xCC and 0xC3 give mode 1 and take two operand bytes. The operand field is (first << 8) | second, and the length is 3.
- R6: The extended opcodes 0xB6, 0xBB and 0xB7 give mode 3 and take two operand bytes, high byte first. The operand field is (first << 8) | second, and the length is 3.
- R7: The one-byte inherent opcodes 0x08, 0x1B and 0x5C give mode 0 with no operand and length 1.
- R8: Prefix 0x18 followed by 0x08 gives one record with opcode 0x1808, mode 0, operand 0 and length 2.
- R9: A first byte that is missing from the table gives opcode 0x00XX, mode 7, operand 0 and length 1. A second-page byte after 0x18 that is missing from the table gives opcode 0x18XX, mode 7, operand 0 and length 2. In both cases decoding resumes with the next byte as a new opcode.
- R10: While `out_valid` is high and `out_ready` is low, the record stays stable and `in_ready` is low. No byte is lost or duplicated under any stall pattern on either side.
- R11: The stream 96 30 8B 07 97 30 96 31 gives four records in order: (0x0096, 2, 0x30), (0x008B, 1, 0x07), (0x0097, 2, 0x30) and (0x0096, 2, 0x31). Each has length 2.
- R12: The upper opcode byte is 0x18 only for prefixed instructions and is zero otherwise. Operand bits above the bytes actually taken are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Machine-code byte |
| out_valid | output | 1 | Instruction record is present |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 16 | Prefix byte (or 0) in the upper byte, opcode in the lower byte |
| out_mode | output | 3 | 0 inherent, 1 immediate, 2 direct, 3 extended, 7 unknown |
| out_operand | output | 24 | Operand bytes, the last one taken in bits 7:0 |
| out_len | output | 3 | Total instruction length in bytes |

## Verification
The assertions check on every cycle that a stalled record holds still and blocks the input. They also check that a finished instruction never lands on a full output register. For every emitted record they check that the mode, length and operand agree (extended means three bytes, unknown means no operand). Only the bench scenarios can show that each opcode maps to the right format and that operand bytes are joined high byte first. They also show that decoding resynchronises after unknown and prefixed bytes, and that a long stream survives random stalls on both sides without losing or repeating a byte.

// File: rtl/isd_pkg.sv
package isd_pkg;
  localparam int BYTE_W  = 8;
  localparam int MAX_OPS = 3;
  localparam int OPS_W   = BYTE_W * MAX_OPS;
  localparam int OPC_W   = 2 * BYTE_W;
  localparam int LEN_W   = 3;
  localparam int CNT_W   = 2;
  localparam logic [BYTE_W-1:0] PAGE_PREFIX = 8'h18;

  typedef enum logic [2:0] {
    MODE_INH = 3'd0,
    MODE_IMM = 3'd1,
    MODE_DIR = 3'd2,
    MODE_EXT = 3'd3,
    MODE_UNK = 3'd7
  } mode_e;

  typedef struct packed {
    mode_e            mode;
    logic [CNT_W-1:0] nops;
  } fmt_t;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    mode_e            mode;
    logic [OPS_W-1:0] ops;
    logic [LEN_W-1:0] len;
  } rec_t;

  function automatic fmt_t fmt_of(input logic page2, input logic [BYTE_W-1:0] b);
    fmt_t f;
    f.mode = MODE_UNK;
    f.nops = '0;
    if (page2) begin
      if (b == 8'h08) f.mode = MODE_INH;
    end else begin
      case (b)
        8'h01, 8'h08, 8'h1B, 8'h5C: f.mode = MODE_INH;
        8'h86, 8'hC6, 8'h8B, 8'hCB: begin f.mode = MODE_IMM; f.nops = 2'd1; end
        8'hCC, 8'hC3:               begin f.mode = MODE_IMM; f.nops = 2'd2; end
        8'h96, 8'hD6, 8'hDC, 8'h9B, 8'hDB, 8'hD3, 8'h97, 8'hD7, 8'hDD:
                                    begin f.mode = MODE_DIR; f.nops = 2'd1; end
        8'hB6, 8'hBB, 8'hB7:        begin f.mode = MODE_EXT; f.nops = 2'd2; end
        default: ;
      endcase
    end
    return f;
  endfunction
endpackage

// File: rtl/isd_fmt_lut.sv
module isd_fmt_lut
  import isd_pkg::*;
(
  input  logic              page2,
  input  logic [BYTE_W-1:0] opc_byte,
  output fmt_t              fmt,
  output logic              is_prefix
);
  always_comb begin
    fmt       = fmt_of(page2, opc_byte);
    is_prefix = !page2 && (opc_byte == PAGE_PREFIX);
  end
endmodule

// File: rtl/isd_gather.sv
module isd_gather
  import isd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  logic [BYTE_W-1:0] in_byte,
  input  fmt_t              fmt,
  input  logic              is_prefix,
  output logic              page2,
  output logic              done,
  output rec_t              rec
);
  typedef enum logic [1:0] {S_OPC, S_PG2, S_OPR} st_e;

  st_e              st_q;
  logic [OPC_W-1:0] opc_q;
  mode_e            mode_q;
  logic [CNT_W-1:0] need_q, cnt_q;
  logic [OPS_W-1:0] ops_q;
  logic [LEN_W-1:0] len_q;
  logic             last_opr;
  logic [OPS_W-1:0] ops_next;

  assign page2    = (st_q == S_PG2);
  assign last_opr = (cnt_q + 1'b1) == need_q;
  assign ops_next = {ops_q[OPS_W-BYTE_W-1:0], in_byte};

  always_comb begin
    done = 1'b0;
    rec  = '0;
    case (st_q)
      S_OPC: begin
        done     = in_fire && !is_prefix && (fmt.nops == '0);
        rec.opc  = {{BYTE_W{1'b0}}, in_byte};
        rec.mode = fmt.mode;
        rec.len  = LEN_W'(1);
      end
      S_PG2: begin
        done     = in_fire && (fmt.nops == '0);
        rec.opc  = {PAGE_PREFIX, in_byte};
        rec.mode = fmt.mode;
        rec.len  = LEN_W'(2);
      end
      default: begin
        done     = in_fire && last_opr;
        rec.opc  = opc_q;
        rec.mode = mode_q;
        rec.ops  = ops_next;
        rec.len  = len_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_OPC;
      opc_q  <= '0;
      mode_q <= MODE_UNK;
      need_q <= '0;
      cnt_q  <= '0;
      ops_q  <= '0;
      len_q  <= '0;
    end else if (in_fire) begin
      case (st_q)
        S_OPC: begin
          if (is_prefix) begin
            st_q <= S_PG2;
          end else if (fmt.nops != '0) begin
            st_q   <= S_OPR;
            opc_q  <= {{BYTE_W{1'b0}}, in_byte};
            mode_q <= fmt.mode;
            need_q <= fmt.nops;
            cnt_q  <= '0;
            ops_q  <= '0;
            len_q  <= LEN_W'(fmt.nops) + LEN_W'(1);
          end
        end
        S_PG2: begin
          if (fmt.nops == '0) begin
            st_q <= S_OPC;
          end else begin
            st_q   <= S_OPR;
            opc_q  <= {PAGE_PREFIX, in_byte};
            mode_q <= fmt.mode;
            need_q <= fmt.nops;
            cnt_q  <= '0;
            ops_q  <= '0;
            len_q  <= LEN_W'(fmt.nops) + LEN_W'(2);
          end
        end
        default: begin
          ops_q <= ops_next;
          cnt_q <= cnt_q + 1'b1;
          if (last_opr) st_q <= S_OPC;
        end
      endcase
    end
  end

  assert_ext_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && rec.mode == MODE_EXT |-> rec.len == LEN_W'(3));
  assert_unk_no_operand_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && rec.mode == MODE_UNK |-> rec.ops == '0 && rec.len <= LEN_W'(2));
  assert_imm_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && rec.mode == MODE_IMM |-> rec.len == LEN_W'(2) || rec.len == LEN_W'(3));
  assert_prefix_hi_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done && rec.len == LEN_W'(1) |-> rec.opc[OPC_W-1:BYTE_W] == '0);
endmodule

// File: rtl/isd_out_reg.sv
module isd_out_reg
  import isd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  rec_t rec_in,
  input  logic out_ready,
  output logic out_valid,
  output rec_t rec_q,
  output logic space
);
  assign space = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rec_q     <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      rec_q     <= rec_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(rec_q));
  assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> space);
endmodule

// File: rtl/instr_split.sv
module instr_split
  import isd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [15:0]      out_opcode,
  output logic [2:0]       out_mode,
  output logic [23:0]      out_operand,
  output logic [2:0]       out_len
);
  fmt_t fmt;
  logic is_prefix, page2, done, space, in_fire;
  rec_t rec_new, rec_q;

  assign in_ready = space;
  assign in_fire  = in_valid && space;

  isd_fmt_lut u_lut (
    .page2(page2), .opc_byte(in_byte), .fmt(fmt), .is_prefix(is_prefix)
  );

  isd_gather u_gather (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .in_byte(in_byte),
    .fmt(fmt), .is_prefix(is_prefix), .page2(page2), .done(done), .rec(rec_new)
  );

  isd_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .load(done), .rec_in(rec_new),
    .out_ready(out_ready), .out_valid(out_valid), .rec_q(rec_q), .space(space)
  );

  assign out_opcode  = rec_q.opc;
  assign out_mode    = rec_q.mode;
  assign out_operand = rec_q.ops;
  assign out_len     = rec_q.len;

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/instr_split_tb_top.sv
module instr_split_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 2048;
  localparam int MAXR = 1024;
  localparam int LIMIT = 60000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, out_valid;
  logic [15:0] out_opcode;
  logic [2:0] out_mode, out_len;
  logic [23:0] out_operand;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_split dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_opcode(out_opcode), .out_mode(out_mode), .out_operand(out_operand),
    .out_len(out_len)
  );

  logic [7:0]  bytes_a [0:MAXB-1];
  logic [15:0] e_opc [0:MAXR-1];
  logic [2:0]  e_mode [0:MAXR-1];
  logic [23:0] e_ops [0:MAXR-1];
  logic [2:0]  e_len [0:MAXR-1];
  string       e_tag [0:MAXR-1];
  int nb = 0, nr = 0, vectors = 0, errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Expected format per the requirement lists: mode in [4:2], operand count in [1:0]
  function automatic logic [4:0] exp_fmt(input logic [7:0] b);
    case (b)
      8'h01, 8'h08, 8'h1B, 8'h5C: return {3'd0, 2'd0};
      8'h86, 8'hC6, 8'h8B, 8'hCB: return {3'd1, 2'd1};
      8'hCC, 8'hC3:               return {3'd1, 2'd2};
      8'h96, 8'hD6, 8'hDC, 8'h9B, 8'hDB, 8'hD3, 8'h97, 8'hD7, 8'hDD: return {3'd2, 2'd1};
      8'hB6, 8'hBB, 8'hB7:        return {3'd3, 2'd2};
      default:                    return {3'd7, 2'd0};
    endcase
  endfunction

  task automatic push_b(input logic [7:0] b);
    bytes_a[nb] = b; nb++;
  endtask

  task automatic push_r(input logic [15:0] o, input logic [2:0] m, input logic [23:0] p,
                        input logic [2:0] l, input string t);
    e_opc[nr] = o; e_mode[nr] = m; e_ops[nr] = p; e_len[nr] = l; e_tag[nr] = t; nr++;
  endtask

  task automatic build();
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b, p1, p2;
      logic [4:0] f;
      string t;
      b = 8'(i);
      if (b == 8'h18) continue;
      f = exp_fmt(b); p1 = b ^ 8'hA5; p2 = b + 8'h3C;
      push_b(b);
      if (f[1:0] >= 2'd1) push_b(p1);
      if (f[1:0] == 2'd2) push_b(p2);
      case (f[4:2])
        3'd0: t = (b == 8'h01) ? "R2" : "R7";
        3'd1: t = (f[1:0] == 2'd1) ? "R3" : "R5";
        3'd2: t = "R4";
        3'd3: t = "R6";
        default: t = "R9";
      endcase
      push_r({8'h00, b}, f[4:2],
             (f[1:0] == 2'd0) ? 24'h0 : (f[1:0] == 2'd1) ? {16'h0, p1} : {8'h0, p1, p2},
             3'(f[1:0]) + 3'd1, t);
    end
    for (int i = 0; i < 256; i++) begin
      push_b(8'h18); push_b(8'(i));
      if (i == 8) push_r(16'h1808, 3'd0, 24'h0, 3'd2, "R8");
      else        push_r({8'h18, 8'(i)}, 3'd7, 24'h0, 3'd2, "R9");
    end
    push_b(8'h96); push_b(8'h30); push_b(8'h8B); push_b(8'h07);
    push_b(8'h97); push_b(8'h30); push_b(8'h96); push_b(8'h31);
    push_r(16'h0096, 3'd2, 24'h30, 3'd2, "R11");
    push_r(16'h008B, 3'd1, 24'h07, 3'd2, "R11");
    push_r(16'h0097, 3'd2, 24'h30, 3'd2, "R11");
    push_r(16'h0096, 3'd2, 24'h31, 3'd2, "R11");
  endtask

  task automatic check(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic run_pass(input logic throttle);
    int bi = 0, ri = 0, cyc = 0;
    logic held = 1'b0;
    logic [44:0] held_rec = '0;
    while (ri < nr && cyc < LIMIT) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid  = (bi < nb) && (!throttle || lfsr[3] || lfsr[7]);
      in_byte   = (bi < nb) ? bytes_a[bi] : 8'h00;
      out_ready = !throttle || lfsr[1] || lfsr[9];
      #1;
      if (held)
        check(out_valid && {out_opcode, out_mode, out_operand, out_len} == held_rec,
              "R10 stalled record stable", {out_opcode, out_mode, out_operand, out_len}, held_rec);
      if (out_valid && !out_ready)
        check(!in_ready, "R10 in_ready low while stalled", in_ready, 0);
      held = 1'b0;
      if (out_valid && out_ready) begin
        check(out_opcode == e_opc[ri] && out_mode == e_mode[ri] &&
              out_operand == e_ops[ri] && out_len == e_len[ri],
              $sformatf("%s record %0d (fields R12)", e_tag[ri], ri),
              {out_opcode, out_mode, out_operand, out_len},
              {e_opc[ri], e_mode[ri], e_ops[ri], e_len[ri]});
        ri++;
      end else if (out_valid) begin
        held = 1'b1;
        held_rec = {out_opcode, out_mode, out_operand, out_len};
      end
      if (in_valid && in_ready) bi++;
      cyc++;
    end
    if (cyc >= LIMIT) begin
      errors++; vectors++;
      $display("FAIL watchdog: R10 stream stalled, records %0d expected %0d", ri, nr);
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && bi == nb, "R10 all bytes consumed, nothing extra", {out_valid, 32'(bi)}, {1'b0, 32'(nb)});
  endtask

  initial begin
    build();
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R1 out_valid after reset", out_valid, 0);
    check(in_ready, "R1 in_ready after reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    run_pass(1'b0);
    run_pass(1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule